// File: doc/BRIEF.md
# Dual-Register Phase Accumulator NCO

This block is a numerically controlled oscillator core. On every clock a 28-bit phase accumulator adds one of two programmed tuning words. The output frequency is therefore the tuning word divided by 2^28, times the clock rate. The top 12 accumulator bits are offset by one of two programmed 12-bit phase words. The upper 10 bits of that offset phase then address a quarter-wave sine table, which is computed at elaboration. The result is a 10-bit offset-binary amplitude code whose midscale value is 512.

The tuning word and the phase word are each chosen either by two select pins or by two control bits. A control bit picks which of the two sources applies. A parallel write port loads the four words and the control register. Writes never disturb the running accumulator.

A functional reset clears only the running state and leaves every programmed word in place. A sleep pin, or a sleep control bit, forces the amplitude output to midscale. A single sign output carries a constant 0, the accumulator MSB or an external comparator input, as set by two control bits. A separate active-low reset initialises everything, including the programmed words.

Top module: `dual_nco`

## Requirements
- R1: On each rising clock edge where `nco_rst` is low, `acc_out` becomes its previous value plus the selected tuning word, modulo 2^28.
- R2: On each such edge, `phase_out` becomes the top 12 bits of the previous `acc_out` plus the selected phase word, modulo 4096.
- R3: One edge after `phase_out` holds p, the stored amplitude is 512 + 511·sin(2π(t+0.5)/1024), within ±2 codes, where t = p[11:2]. A p with bit 11 set gives a value at or below 512, and any other p gives a value above 512.
- R4: Control bit 2 picks the select source. When it is 1, `fsel_pin` and `psel_pin` choose bank 1 (when high) or bank 0. When it is 0, control bits 0 (tuning) and 1 (phase) choose the bank, and the pins have no effect.
- R5: With `we` high, `waddr` 0, 1, 2, 3 and 4 load tuning word 0, tuning word 1, phase word 0 (from `wdata[11:0]`), phase word 1 and the control register (from `wdata[5:0]`). Each write lands on that edge, and the accumulator keeps stepping by the word that was selected before the edge. Addresses 5 to 7 change nothing.
- R6: An edge with `nco_rst` high sets `acc_out` and `phase_out` to 0 and the stored amplitude to 512. All programmed words and control bits are kept.
- R7: While `sleep` or control bit 3 is high, `amp_out` is 512 without delay, and the accumulator keeps running.
- R8: `sign_out` is 0 when control bit 4 is 0. When bit 4 is 1 and control bit 5 is 0, it equals `acc_out[27]`. When both are 1, it follows `cmp_in` combinationally.
- R9: While `rst_n` is low, all state and all programmed words are 0. After its release with no writes, `acc_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state and words |
| nco_rst | input | 1 | Synchronous active-high clear of accumulator and pipeline |
| sleep | input | 1 | Forces amplitude to midscale |
| fsel_pin | input | 1 | External tuning-word select |
| psel_pin | input | 1 | External phase-word select |
| cmp_in | input | 1 | External comparator level for the sign output |
| we | input | 1 | Write strobe |
| waddr | input | 3 | Write address |
| wdata | input | 28 | Write data |
| amp_out | output | 10 | Offset-binary sine amplitude |
| sign_out | output | 1 | Selectable sign bit |
| acc_out | output | 28 | Phase accumulator value |
| phase_out | output | 12 | Offset phase (pipeline stage) |

## Verification
The accumulator reflects the selected tuning word one edge after the select or write settles. `phase_out` trails the accumulator by one edge, and the stored amplitude trails `phase_out` by one more. So after a functional reset and n edges, the bench expects n·F, top((n−1)·F)+P and sine(top((n−2)·F)+P). The sleep gate and the sign multiplexer are combinational, so they are checked a short settle time after the input moves. Every input is driven on the falling edge and every output is sampled there, half a period after the register update it depends on.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef struct packed {
    logic sign_src;   // bit 5: 1 = comparator, 0 = accumulator MSB
    logic sign_en;    // bit 4
    logic sleep;      // bit 3
    logic pin_sw;     // bit 2: 1 = select pins
    logic psel;       // bit 1
    logic fsel;       // bit 0
  } nco_ctrl_t;

  localparam int CTRL_W = $bits(nco_ctrl_t);

  typedef enum logic [2:0] {
    WA_FREQ0  = 3'd0,
    WA_FREQ1  = 3'd1,
    WA_PHASE0 = 3'd2,
    WA_PHASE1 = 3'd3,
    WA_CTRL   = 3'd4
  } nco_waddr_e;

  // Rational sine approximation of a quarter-wave sample k (half-step centred),
  // scaled to the positive full range of an amp_w-bit offset-binary code.
  function automatic int unsigned quarter_mag(input int unsigned k,
                                              input int unsigned qbits,
                                              input int unsigned amp_w);
    longint h;
    longint x;
    longint prod;
    longint den;
    longint a;
    h    = longint'(4) * (longint'(1) << qbits);
    x    = 2 * longint'(k) + 1;
    prod = x * (h - x);
    den  = (5 * h * h) / 4 - prod;
    a    = (longint'(1) << (amp_w - 1)) - 1;
    return 32'((4 * a * prod + den / 2) / den);
  endfunction

endpackage

// File: rtl/nco_regbank.sv
module nco_regbank
  import nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [2:0]                 waddr,
  input  logic [ACC_W-1:0]           wdata,
  output logic [1:0][ACC_W-1:0]      freq_q,
  output logic [1:0][PH_W-1:0]       phase_q,
  output nco_ctrl_t                  ctrl_q
);

  logic [1:0] freq_hit;
  logic [1:0] phase_hit;
  logic       ctrl_hit;
  logic       wr_reserved;

  for (genvar b = 0; b < 2; b++) begin : g_bank_dec
    assign freq_hit[b]  = we && (waddr == 3'(int'(WA_FREQ0) + b));
    assign phase_hit[b] = we && (waddr == 3'(int'(WA_PHASE0) + b));
  end

  assign ctrl_hit    = we && (waddr == WA_CTRL);
  assign wr_reserved = we && (waddr > WA_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q  <= '0;
      phase_q <= '0;
      ctrl_q  <= '0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (freq_hit[b])  freq_q[b]  <= wdata;
        if (phase_hit[b]) phase_q[b] <= wdata[PH_W-1:0];
      end
      if (ctrl_hit) ctrl_q <= nco_ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  // R5
  reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reserved |=> ($stable(freq_q) && $stable(phase_q) && $stable(ctrl_q)));

endmodule

// File: rtl/nco_phase_path.sv
module nco_phase_path #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nco_rst,
  input  logic [ACC_W-1:0] step,
  input  logic [PH_W-1:0]  poff,
  output logic [ACC_W-1:0] acc_q,
  output logic [PH_W-1:0]  phase_q
);

  function automatic logic [ACC_W:0] acc_add(input logic [ACC_W-1:0] a,
                                             input logic [ACC_W-1:0] s);
    return {1'b0, a} + {1'b0, s};
  endfunction

  function automatic logic [PH_W-1:0] offset_phase(input logic [ACC_W-1:0] a,
                                                   input logic [PH_W-1:0] p);
    return a[ACC_W-1 -: PH_W] + p;
  endfunction

  logic [ACC_W-1:0] acc_sum;
  logic             acc_carry;

  assign {acc_carry, acc_sum} = acc_add(acc_q, step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      phase_q <= '0;
    end else if (nco_rst) begin
      acc_q   <= '0;
      phase_q <= '0;
    end else begin
      acc_q   <= acc_sum;
      phase_q <= offset_phase(acc_q, poff);
    end
  end

  // R1
  acc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_carry && !nco_rst) |=> (acc_q < $past(acc_q)));

  // R1
  acc_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_carry && !nco_rst) |=> (acc_q >= $past(acc_q)));

  // R6
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nco_rst |=> (acc_q == '0 && phase_q == '0));

endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut
  import nco_pkg::*;
#(
  parameter int LUT_BITS = 10,
  parameter int AMP_W    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                nco_rst,
  input  logic [LUT_BITS-1:0] lut_addr,
  output logic [AMP_W-1:0]    amp_q
);

  localparam int QBITS = LUT_BITS - 2;
  localparam int QN    = 1 << QBITS;
  localparam int MAG_W = AMP_W - 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

  logic [MAG_W-1:0] rom [QN];

  for (genvar k = 0; k < QN; k++) begin : g_rom
    assign rom[k] = MAG_W'(quarter_mag(k, QBITS, AMP_W));
  end

  logic [1:0]       quad;
  logic [QBITS-1:0] idx;
  logic [QBITS-1:0] rom_idx;
  logic [MAG_W-1:0] mag;
  logic [AMP_W-1:0] amp_d;
  logic             neg_half;

  assign quad     = lut_addr[LUT_BITS-1 -: 2];
  assign idx      = lut_addr[QBITS-1:0];
  assign rom_idx  = quad[0] ? ~idx : idx;
  assign mag      = rom[rom_idx];
  assign neg_half = quad[1];
  assign amp_d    = neg_half ? (MID - AMP_W'(mag)) : (MID + AMP_W'(mag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       amp_q <= MID;
    else if (nco_rst) amp_q <= MID;
    else              amp_q <= amp_d;
  end

  // R3
  neg_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_half && !nco_rst) |=> (amp_q <= MID));

  // R3
  pos_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!neg_half && !nco_rst) |=> (amp_q > MID));

endmodule

// File: rtl/dual_nco.sv
module dual_nco
  import nco_pkg::*;
#(
  parameter int ACC_W    = 28,
  parameter int PH_W     = 12,
  parameter int LUT_BITS = 10,
  parameter int AMP_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nco_rst,
  input  logic             sleep,
  input  logic             fsel_pin,
  input  logic             psel_pin,
  input  logic             cmp_in,
  input  logic             we,
  input  logic [2:0]       waddr,
  input  logic [ACC_W-1:0] wdata,
  output logic [AMP_W-1:0] amp_out,
  output logic             sign_out,
  output logic [ACC_W-1:0] acc_out,
  output logic [PH_W-1:0]  phase_out
);

  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

  logic [1:0][ACC_W-1:0] freq_q;
  logic [1:0][PH_W-1:0]  phase_q;
  nco_ctrl_t             ctrl_q;
  logic                  fsel_eff;
  logic                  psel_eff;
  logic [ACC_W-1:0]      step;
  logic [PH_W-1:0]       poff;
  logic [AMP_W-1:0]      amp_q;
  logic                  sleep_any;
  logic                  nco_msb;

  nco_regbank #(.ACC_W(ACC_W), .PH_W(PH_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .freq_q(freq_q), .phase_q(phase_q), .ctrl_q(ctrl_q)
  );

  assign fsel_eff = ctrl_q.pin_sw ? fsel_pin : ctrl_q.fsel;
  assign psel_eff = ctrl_q.pin_sw ? psel_pin : ctrl_q.psel;
  assign step     = freq_q[fsel_eff];
  assign poff     = phase_q[psel_eff];

  nco_phase_path #(.ACC_W(ACC_W), .PH_W(PH_W)) path_i (
    .clk(clk), .rst_n(rst_n), .nco_rst(nco_rst), .step(step), .poff(poff),
    .acc_q(acc_out), .phase_q(phase_out)
  );

  nco_sine_lut #(.LUT_BITS(LUT_BITS), .AMP_W(AMP_W)) lut_i (
    .clk(clk), .rst_n(rst_n), .nco_rst(nco_rst),
    .lut_addr(phase_out[PH_W-1 -: LUT_BITS]), .amp_q(amp_q)
  );

  assign sleep_any = sleep | ctrl_q.sleep;
  assign amp_out   = sleep_any ? MID : amp_q;

  assign nco_msb  = acc_out[ACC_W-1];
  assign sign_out = ctrl_q.sign_en ? (ctrl_q.sign_src ? cmp_in : nco_msb) : 1'b0;

  // R7
  sleep_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (amp_out == MID));

  // R8
  sign_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.sign_en |-> !sign_out);

  // R4
  pin_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.pin_sw && !nco_rst) |=>
      (acc_out == $past(acc_out) + (($past(fsel_pin)) ? $past(freq_q[1]) : $past(freq_q[0]))));

endmodule

// File: tb/dual_nco_tb.sv
module dual_nco_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  typedef struct packed {
    logic [27:0] f0;
    logic [27:0] f1;
    logic [11:0] p0;
    logic [11:0] p1;
    logic [5:0]  ctrl;
    logic        fpin;
    logic        ppin;
    logic [7:0]  n;
  } vec_t;

  // ctrl bits: 0 fsel, 1 psel, 2 pin_sw, 3 sleep, 4 sign_en, 5 sign_src
  localparam vec_t VECS [NV] = '{
    '{28'h0100000, 28'h0040000, 12'h000, 12'h400, 6'b000000, 1'b0, 1'b0, 8'd5},
    '{28'h0100000, 28'h0040000, 12'h000, 12'h400, 6'b000011, 1'b0, 1'b0, 8'd7},
    '{28'h0333333, 28'h0055555, 12'h123, 12'h800, 6'b000100, 1'b1, 1'b0, 8'd4},
    '{28'h0333333, 28'h0055555, 12'h123, 12'h800, 6'b000111, 1'b0, 1'b1, 8'd6},
    '{28'hFFFFFFF, 28'h0000010, 12'h000, 12'h000, 6'b010000, 1'b0, 1'b0, 8'd9},
    '{28'h9000000, 28'h0000001, 12'h0F0, 12'h000, 6'b111000, 1'b0, 1'b1, 8'd3},
    '{28'h0000100, 28'h2345678, 12'h000, 12'hFFF, 6'b010011, 1'b0, 1'b0, 8'd20}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nco_rst = 1'b0;
  logic        sleep = 1'b0;
  logic        fsel_pin = 1'b0;
  logic        psel_pin = 1'b0;
  logic        cmp_in = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  waddr = '0;
  logic [27:0] wdata = '0;
  logic [9:0]  amp_out;
  logic        sign_out;
  logic [27:0] acc_out;
  logic [11:0] phase_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_nco dut_i (
    .clk(clk), .rst_n(rst_n), .nco_rst(nco_rst), .sleep(sleep),
    .fsel_pin(fsel_pin), .psel_pin(psel_pin), .cmp_in(cmp_in),
    .we(we), .waddr(waddr), .wdata(wdata),
    .amp_out(amp_out), .sign_out(sign_out), .acc_out(acc_out), .phase_out(phase_out)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [27:0] d);
    we = 1'b1; waddr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int sine_code(input logic [11:0] p);
    real ang;
    ang = 2.0 * 3.14159265358979 * (real'(p[11:2]) + 0.5) / 1024.0;
    return $rtoi(512.0 + 511.0 * $sin(ang) + 0.5);
  endfunction

  task automatic chk_amp(input string req, input logic [9:0] act, input int exp);
    int d;
    n_cmp++;
    d = int'(act) - exp;
    if (d > 2 || d < -2) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [27:0] f, g, h, a0, prod;
    logic [11:0] p, ephase, eprev;
    logic        fs, ps;
    vec_t        v;

    // R9: reset state
    repeat (2) tick();
    chk("R9 acc", 32'(acc_out), 32'h0);
    chk("R9 phase", 32'(phase_out), 32'h0);
    chk("R9 amp", 32'(amp_out), 32'd512);
    chk("R9 sign", 32'(sign_out), 32'h0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R9 words cleared", 32'(acc_out), 32'h0);

    // Vector table: R1 R2 R3 R4 R7 R8
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      wr(3'd0, v.f0); wr(3'd1, v.f1);
      wr(3'd2, 28'(v.p0)); wr(3'd3, 28'(v.p1));
      wr(3'd4, 28'(v.ctrl));
      fsel_pin = v.fpin; psel_pin = v.ppin; cmp_in = v.ppin;
      nco_rst = 1'b1; tick(); nco_rst = 1'b0;
      repeat (int'(v.n)) tick();
      fs = v.ctrl[2] ? v.fpin : v.ctrl[0];
      ps = v.ctrl[2] ? v.ppin : v.ctrl[1];
      f = fs ? v.f1 : v.f0;
      p = ps ? v.p1 : v.p0;
      prod   = f * 28'(v.n - 8'd1);
      ephase = prod[27:16] + p;
      prod   = f * 28'(v.n - 8'd2);
      eprev  = prod[27:16] + p;
      prod   = f * 28'(v.n);
      chk($sformatf("R1 R4 acc vec%0d", i), 32'(acc_out), 32'(prod));
      chk($sformatf("R2 R4 phase vec%0d", i), 32'(phase_out), 32'(ephase));
      if (v.ctrl[3]) chk($sformatf("R7 amp vec%0d", i), 32'(amp_out), 32'd512);
      else chk_amp($sformatf("R3 amp vec%0d", i), amp_out, sine_code(eprev));
      chk($sformatf("R8 sign vec%0d", i), 32'(sign_out),
          32'(v.ctrl[4] ? (v.ctrl[5] ? v.ppin : prod[27]) : 1'b0));
    end

    // R6: functional reset keeps words
    f = 28'h0123457;
    wr(3'd0, f); wr(3'd2, 28'h0); wr(3'd4, 28'h0);
    nco_rst = 1'b1; tick(); nco_rst = 1'b0;
    repeat (10) tick();
    chk("R6 pre acc", 32'(acc_out), 32'(f * 28'd10));
    nco_rst = 1'b1; tick();
    chk("R6 acc clear", 32'(acc_out), 32'h0);
    chk("R6 phase clear", 32'(phase_out), 32'h0);
    chk("R6 amp mid", 32'(amp_out), 32'd512);
    nco_rst = 1'b0;
    repeat (3) tick();
    chk("R6 words kept", 32'(acc_out), 32'(f * 28'd3));

    // R5: reserved addresses ignored
    cmp_in = 1'b1;
    wr(3'd5, 28'hFFFFFFF); wr(3'd6, 28'hFFFFFFF); wr(3'd7, 28'hFFFFFFF);
    nco_rst = 1'b1; tick(); nco_rst = 1'b0;
    repeat (4) tick();
    chk("R5 reserved acc", 32'(acc_out), 32'(f * 28'd4));
    chk("R5 reserved phase", 32'(phase_out), 32'((f * 28'd3) >> 16));
    chk("R5 reserved ctrl", 32'(sign_out), 32'h0);

    // R5: write to selected word mid-run
    g = 28'h0200000;
    a0 = acc_out;
    wr(3'd0, g);
    chk("R5 write edge uses old word", 32'(acc_out), 32'(a0 + f));
    tick();
    chk("R5 new word next edge", 32'(acc_out), 32'(a0 + f + g));
    h = 28'h0011111;
    a0 = acc_out;
    wr(3'd1, h);
    tick();
    chk("R5 unselected write", 32'(acc_out), 32'(a0 + g + g));

    // R7: sleep pin
    sleep = 1'b1; #1;
    chk("R7 sleep amp", 32'(amp_out), 32'd512);
    a0 = acc_out;
    tick();
    chk("R7 sleep runs", 32'(acc_out), 32'(a0 + g));
    sleep = 1'b0;
    p = phase_out;
    tick();
    chk_amp("R3 after wake", amp_out, sine_code(p));

    // R8: sign multiplexer
    wr(3'd4, 28'b100000);
    cmp_in = 1'b1; #1;
    chk("R8 disabled", 32'(sign_out), 32'h0);
    wr(3'd4, 28'b110000); #1;
    chk("R8 cmp high", 32'(sign_out), 32'h1);
    cmp_in = 1'b0; #1;
    chk("R8 cmp low", 32'(sign_out), 32'h0);

    // R4: pins take over
    wr(3'd4, 28'b000100);
    fsel_pin = 1'b1;
    a0 = acc_out;
    tick();
    chk("R4 pin bank1", 32'(acc_out), 32'(a0 + h));
    fsel_pin = 1'b0;
    tick();
    chk("R4 pin bank0", 32'(acc_out), 32'(a0 + h + g));

    finish_run();
  end

endmodule